// File: doc/BRIEF.md
# Serial Flash Status Register Front End

This block is the command front end of a serial NOR flash slave, limited to the status register. It watches a mode-0 SPI link made of a serial clock, an active-low select, a data input and a data output, all sampled by the chip's system clock. It decodes three opcodes: write-enable, read-status and write-status. A status write is gated by the write-enable latch, by an exact byte-aligned end of the transfer, and by a hardware lock. The lock is formed by the status-lock bit together with an active-low write-protect pin.

An accepted status write does not land at once. The new byte is staged when the select line rises and a self-timed cycle begins. Its length is a parameter in system clocks and stands in for non-volatile programming. During that cycle the busy flag reads 1 and can be polled. At the end the staged value is committed, the busy flag drops and the write-enable latch clears. The four protection-level bits are exported for an array-protection check elsewhere.

Status byte layout, MSB to LSB: bit7 status-lock, bit6 fixed 0, bits5..2 protection level (bit5 most significant), bit1 write-enable latch, bit0 busy.

Top module: `spi_status_reg`

## Requirements
- R1: After reset the status byte reads 0x00, blockProtect is 0 and serialOut is 0.
- R2: Opcode 0x06 sets the write-enable latch (status bit1).
- R3: Opcode 0x05 shifts the live status byte out MSB first. serialIn is sampled on rising spiClk and serialOut changes on falling spiClk, starting at the first falling edge after the opcode. The byte repeats for as long as chipSelN stays low, bit6 always reads 0, and serialOut is 0 while chipSelN is high.
- R4: Opcode 0x01 is ignored when the write-enable latch is 0.
- R5: While status bit7 is 1 and writeProtN is low, opcode 0x01 is rejected and bits 7 and 5..2 keep their values. With writeProtN high the same write is accepted.
- R6: A status write runs only if chipSelN rises directly after the eighth data bit. A rise after fewer data bits, or after any further spiClk rising edge, discards it.
- R7: An accepted write sets the busy flag for WRITE_CYCLES clocks from the select rise, and bits 7 and 5..2 keep their old values during that time. At the end they take the data byte's values, the busy flag returns to 0 and the write-enable latch clears.
- R8: While the busy flag is 1, every opcode other than 0x05 is ignored.
- R9: Data bits 6, 1 and 0 of a status write have no effect on the register.
- R10: blockProtect always equals the committed status bits 5..2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rstN | input | 1 | Active-low asynchronous reset |
| spiClk | input | 1 | SPI serial clock, idle low (mode 0) |
| chipSelN | input | 1 | Active-low select framing each command |
| serialIn | input | 1 | Serial data from the host |
| writeProtN | input | 1 | Active-low hardware write-protect pin |
| serialOut | output | 1 | Serial status data to the host |
| blockProtect | output | 4 | Committed protection-level bits 5..2 |

## Verification
The bench builds the block with WRITE_CYCLES set to 100. With that value one two-byte status read issued right after a write sees the busy flag set in its first byte and the committed value in its second. That same short cycle keeps a full sweep of all 256 status write data values within the run, and every value is predicted arithmetically from the bit layout. Directed transfers cover truncated and overlong writes, writes issued while busy, and the hardware lock on both levels of the protect pin.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;

  localparam logic [7:0] OP_WRITE_ENABLE = 8'h06;
  localparam logic [7:0] OP_READ_STATUS  = 8'h05;
  localparam logic [7:0] OP_WRITE_STATUS = 8'h01;

  // strobes from control to datapath
  typedef struct packed {
    logic setWel;
    logic stageData;
    logic startWrite;
    logic readMode;
  } srCtrlT;

  // events and state from datapath to control
  typedef struct packed {
    logic       csFall;
    logic       csRise;
    logic       sclkRise;
    logic       byteDone;
    logic [7:0] rxByte;
    logic       onBoundary;
    logic       wel;
    logic       wip;
    logic       hwProtect;
  } srEvtT;

endpackage

// File: rtl/spi_sr_sync.sv
module spi_sr_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {STAGES{RESET_VAL}};
    else       pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_sr_datapath.sv
module spi_sr_datapath
  import spi_sr_pkg::*;
#(
  parameter int WRITE_CYCLES = 4096,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiClk,
  input  logic       chipSelN,
  input  logic       serialIn,
  input  logic       writeProtN,
  input  srCtrlT     ctrl,
  output srEvtT      evt,
  output logic       serialOut,
  output logic [3:0] blockProtect
);
  localparam int NUM_PINS = 4;
  localparam int TIMER_W  = $clog2(WRITE_CYCLES + 1);
  localparam logic [NUM_PINS-1:0] PIN_RST = 4'b1010; // {wp, cs, si, sclk}

  logic [NUM_PINS-1:0] pinRaw, pinSync;
  assign pinRaw = {writeProtN, chipSelN, serialIn, spiClk};

  for (genvar i = 0; i < NUM_PINS; i++) begin : gSync
    spi_sr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(PIN_RST[i])) syncI (
      .clk(clk), .rstN(rstN), .d(pinRaw[i]), .q(pinSync[i])
    );
  end

  logic sclkS, siS, csS, wpS;
  assign sclkS = pinSync[0];
  assign siS   = pinSync[1];
  assign csS   = pinSync[2];
  assign wpS   = pinSync[3];

  logic sclkPrev, csPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkPrev <= sclkS;
      csPrev   <= csS;
    end
  end

  logic sclkRise, sclkFall, csRise, csFall;
  assign sclkRise = sclkS & ~sclkPrev & ~csS;
  assign sclkFall = ~sclkS & sclkPrev & ~csS;
  assign csRise   = csS & ~csPrev;
  assign csFall   = ~csS & csPrev;

  // receive shifter
  logic [2:0] bitCnt;
  logic [6:0] rxShift;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
    end else if (csFall) begin
      bitCnt  <= '0;
    end else if (sclkRise) begin
      bitCnt  <= bitCnt + 3'd1;
      rxShift <= {rxShift[5:0], siS};
    end
  end

  // status register and self-timed write
  logic               srwd, wel, wip;
  logic [3:0]         bp;
  logic [4:0]         stage;
  logic [TIMER_W-1:0] timer;
  logic [7:0]         statusByte;
  assign statusByte = {srwd, 1'b0, bp, wel, wip};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srwd  <= 1'b0;
      bp    <= '0;
      wel   <= 1'b0;
      wip   <= 1'b0;
      stage <= '0;
      timer <= '0;
    end else begin
      if (ctrl.setWel) wel <= 1'b1;
      if (ctrl.stageData) stage <= {evt.rxByte[7], evt.rxByte[5:2]};
      if (ctrl.startWrite) begin
        wip   <= 1'b1;
        timer <= TIMER_W'(WRITE_CYCLES - 1);
      end else if (wip) begin
        if (timer == '0) begin
          wip  <= 1'b0;
          wel  <= 1'b0;
          srwd <= stage[4];
          bp   <= stage[3:0];
        end else begin
          timer <= timer - 1'b1;
        end
      end
    end
  end

  // transmit shifter, updated on falling SCLK
  logic [6:0] txShift;
  logic [2:0] txIdx;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift   <= '0;
      txIdx     <= '0;
      serialOut <= 1'b0;
    end else if (csS) begin
      txIdx     <= '0;
      serialOut <= 1'b0;
    end else if (ctrl.readMode && sclkFall) begin
      txIdx <= txIdx + 3'd1;
      if (txIdx == 3'd0) begin
        serialOut <= statusByte[7];
        txShift   <= statusByte[6:0];
      end else begin
        serialOut <= txShift[6];
        txShift   <= {txShift[5:0], 1'b0};
      end
    end
  end

  assign blockProtect = bp;

  always_comb begin
    evt            = '0;
    evt.csFall     = csFall;
    evt.csRise     = csRise;
    evt.sclkRise   = sclkRise;
    evt.byteDone   = sclkRise && (bitCnt == 3'd7);
    evt.rxByte     = {rxShift, siS};
    evt.onBoundary = (bitCnt == 3'd0);
    evt.wel        = wel;
    evt.wip        = wip;
    evt.hwProtect  = srwd & ~wpS;
  end

  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.startWrite |-> (wel && !wip)); // R4
  AST_HWP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (srwd && !wpS && !wip) |=> $stable({srwd, bp})); // R5
  AST_START_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.startWrite |-> (csRise && bitCnt == 3'd0)); // R6
  AST_COMMIT_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> !wel); // R7
  AST_SO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> !serialOut); // R3
endmodule

// File: rtl/spi_sr_control.sv
module spi_sr_control
  import spi_sr_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  srEvtT  evt,
  output srCtrlT ctrl
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_DATA, ST_ARMED, ST_READ, ST_SKIP
  } stateT;

  stateT st, stNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stNext = st;
    ctrl   = '0;
    if (evt.csFall) begin
      stNext = ST_CMD;
    end else if (evt.csRise) begin
      if (st == ST_ARMED && evt.onBoundary) ctrl.startWrite = 1'b1;
      stNext = ST_IDLE;
    end else begin
      case (st)
        ST_CMD: if (evt.byteDone) begin
          if (evt.rxByte == OP_READ_STATUS) begin
            stNext = ST_READ;
          end else if (evt.wip) begin
            stNext = ST_SKIP;
          end else if (evt.rxByte == OP_WRITE_ENABLE) begin
            ctrl.setWel = 1'b1;
            stNext      = ST_SKIP;
          end else if (evt.rxByte == OP_WRITE_STATUS && evt.wel && !evt.hwProtect) begin
            stNext = ST_DATA;
          end else begin
            stNext = ST_SKIP;
          end
        end
        ST_DATA: if (evt.byteDone) begin
          ctrl.stageData = 1'b1;
          stNext         = ST_ARMED;
        end
        ST_ARMED: if (evt.sclkRise) stNext = ST_SKIP;
        default: ;
      endcase
    end
    ctrl.readMode = (st == ST_READ);
  end

  AST_WIP_NO_CMD: assert property (@(posedge clk) disable iff (!rstN)
    evt.wip |-> !(ctrl.setWel || ctrl.stageData)); // R8
  AST_ARMED_ONLY_AFTER_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (stNext == ST_ARMED && st != ST_ARMED) |-> ctrl.stageData); // R6
endmodule

// File: rtl/spi_status_reg.sv
module spi_status_reg
  import spi_sr_pkg::*;
#(
  parameter int WRITE_CYCLES = 4096,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       spiClk,
  input  logic       chipSelN,
  input  logic       serialIn,
  input  logic       writeProtN,
  output logic       serialOut,
  output logic [3:0] blockProtect
);
  srCtrlT ctrl;
  srEvtT  evt;

  spi_sr_datapath #(.WRITE_CYCLES(WRITE_CYCLES), .SYNC_STAGES(SYNC_STAGES)) dpI (
    .clk(clk), .rstN(rstN), .spiClk(spiClk), .chipSelN(chipSelN),
    .serialIn(serialIn), .writeProtN(writeProtN), .ctrl(ctrl), .evt(evt),
    .serialOut(serialOut), .blockProtect(blockProtect)
  );

  spi_sr_control ctlI (
    .clk(clk), .rstN(rstN), .evt(evt), .ctrl(ctrl)
  );
endmodule

// File: tb/spi_status_reg_tb.sv
module spi_status_reg_tb_top;
  localparam int WCYC = 100;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiClk = 1'b0;
  logic chipSelN = 1'b1;
  logic serialIn = 1'b0;
  logic writeProtN = 1'b1;
  logic serialOut;
  logic [3:0] blockProtect;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;
  logic [7:0] rdBuf [0:3];

  always #10 clk = ~clk; // 50 MHz

  spi_status_reg #(.WRITE_CYCLES(WCYC)) dut_i (
    .clk(clk), .rstN(rstN), .spiClk(spiClk), .chipSelN(chipSelN),
    .serialIn(serialIn), .writeProtN(writeProtN),
    .serialOut(serialOut), .blockProtect(blockProtect)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  task automatic csLow();
    chipSelN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic csHigh();
    waitClk(HALF);
    chipSelN = 1'b1;
    waitClk(2 * HALF);
  endtask

  // shift n bits of d (MSB first), returning what was seen on serialOut
  task automatic xferBits(input logic [7:0] d, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < n; i++) begin
      serialIn = d[7 - i];
      waitClk(HALF);
      rx = {rx[6:0], serialOut};
      spiClk = 1'b1;
      waitClk(HALF);
      spiClk = 1'b0;
    end
  endtask

  task automatic cmdByte(input logic [7:0] op);
    logic [7:0] junk;
    csLow();
    xferBits(op, 8, junk);
    csHigh();
  endtask

  task automatic writeStatus(input logic [7:0] d);
    logic [7:0] junk;
    csLow();
    xferBits(8'h01, 8, junk);
    xferBits(d, 8, junk);
    csHigh();
  endtask

  task automatic rdStatus(input int n);
    logic [7:0] junk;
    csLow();
    xferBits(8'h05, 8, junk);
    for (int i = 0; i < n; i++) xferBits(8'h00, 8, rdBuf[i]);
    csHigh();
  endtask

  function automatic logic [7:0] expStatus(input logic [7:0] d);
    return {d[7], 1'b0, d[5:2], 2'b00};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    finishRun();
  end

  initial begin
    logic [7:0] junk;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);

    // R1 reset state
    check("R1 serialOut", {7'd0, serialOut}, 8'h00);
    check("R1 blockProtect", {4'd0, blockProtect}, 8'h00);
    rdStatus(1);
    check("R1 status", rdBuf[0], 8'h00);

    // R4 write without latch
    writeStatus(8'h3C);
    waitClk(WCYC + 20);
    rdStatus(1);
    check("R4 no latch", rdBuf[0], 8'h00);

    // R2 write enable
    cmdByte(8'h06);
    rdStatus(1);
    check("R2 latch set", rdBuf[0], 8'h02);

    // R6 truncated data byte
    csLow();
    xferBits(8'h01, 8, junk);
    xferBits(8'h3C, 5, junk);
    csHigh();
    waitClk(WCYC + 20);
    rdStatus(1);
    check("R6 short", rdBuf[0], 8'h02);

    // R6 extra bits after data byte
    csLow();
    xferBits(8'h01, 8, junk);
    xferBits(8'h3C, 8, junk);
    xferBits(8'hFF, 3, junk);
    csHigh();
    waitClk(WCYC + 20);
    rdStatus(1);
    check("R6 overlong", rdBuf[0], 8'h02);

    // R7 timed write, polled in one two-byte read
    writeStatus(8'h3C);
    check("R7 bp held", {4'd0, blockProtect}, 8'h00);
    rdStatus(2);
    check("R7 busy", rdBuf[0], 8'h03);
    check("R7 committed", rdBuf[1], 8'h3C);
    check("R10 bp", {4'd0, blockProtect}, 8'h0F);

    // R8 second write while busy is ignored
    cmdByte(8'h06);
    writeStatus(8'h24);
    writeStatus(8'h18);
    waitClk(WCYC + 20);
    rdStatus(1);
    check("R8 busy ignores", rdBuf[0], 8'h24);

    // R9 data bits 6,1,0 ignored
    cmdByte(8'h06);
    writeStatus(8'hD7);
    waitClk(WCYC + 20);
    rdStatus(1);
    check("R9 masked", rdBuf[0], 8'h94);

    // R5 hardware lock
    writeProtN = 1'b0;
    waitClk(10);
    cmdByte(8'h06);
    writeStatus(8'h00);
    waitClk(WCYC + 20);
    rdStatus(1);
    check("R5 locked", rdBuf[0], 8'h96);
    check("R5 bp locked", {4'd0, blockProtect}, 8'h05);
    writeProtN = 1'b1;
    waitClk(10);
    writeStatus(8'h00);
    waitClk(WCYC + 20);
    rdStatus(1);
    check("R5 unlocked", rdBuf[0], 8'h00);

    // R3 repeated status bytes in one transfer
    cmdByte(8'h06);
    rdStatus(3);
    for (int i = 0; i < 3; i++) check("R3 repeat", rdBuf[i], 8'h02);
    check("R3 idle out", {7'd0, serialOut}, 8'h00);

    // sweep of all data values (R7, R9, R10)
    for (int d = 0; d < 256; d++) begin
      cmdByte(8'h06);
      writeStatus(8'(d));
      waitClk(WCYC + 10);
      rdStatus(1);
      check("R9 sweep", rdBuf[0], expStatus(8'(d)));
      check("R10 sweep", {4'd0, blockProtect}, {4'd0, 4'(d >> 2)});
    end

    finishRun();
  end
endmodule